// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block is the software-visible control and status register bank of an ECC memory controller. A 32-bit word port reaches nine registers: memory enable, timing delay, fault status, video configuration, two fault address words, a diagnostic word and two event counters. Each register has its own writable-bit mask. The enable register also carries a read-only identity byte and a set of bits that survive reset, and both depend on the chip variant, which is fixed by the `VARIANT` parameter (0, 1 or 2).

Error detection hardware loads the fault status and both fault address registers through a capture port, and that load raises the interrupt. Software acknowledges the interrupt by writing the fault status register. Variant 0 also has a four-byte diagnostic window with byte-wide access. In the other variants that window reads as zero and ignores writes.

Top module: `ecc_regbank`

## Requirements
- R1: The word index is `reg_addr_i[5:2]`. Indices 0..8 select, in order: enable, delay, fault status, video, fault address 0, fault address 1, diagnostic, event count 0, event count 1. Read data appears on `reg_rdata_o` one clock after the read request and holds until the next read.
- R2: An access counts only when `reg_be_i` is 4'hF and `reg_addr_i[1:0]` is 0. Any other write is ignored, and any other read returns zero.
- R3: A write to enable stores the written data masked with 0x00000103 in variant 0 and with 0x00000BFF in variants 1 and 2. Bits 31:24 always read as the identity byte: 0x00, 0x10 or 0x20 for variant 0, 1 or 2.
- R4: The delay register stores the written data masked with 0x7FFFFFFF, so bit 31 always reads zero.
- R5: A write to fault status stores the full word, and `irq_o` is low from the next clock unless a capture happens in the same cycle.
- R6: When `err_valid_i` is high, the next clock loads fault status from `err_status_i`, fault address 0 from `err_addr0_i` and fault address 1 from `err_addr1_i`, and sets `irq_o`. A capture takes precedence over a bus write to fault status in the same cycle.
- R7: Bus writes to the two fault address registers have no effect.
- R8: Reset sets delay to 0x00000020, fault address 0 to 0x07C00000, `irq_o` low and every other register to zero, with the enable register handled as in R9.
- R9: Across reset, enable bit 8 is kept in variant 0. Bits 11 and 9:2 are kept in variants 1 and 2. All other non-identity enable bits clear.
- R10: Event count 1 is separate storage at index 8. It is written and read independently of event count 0.
- R11: Indices 9..15 read as zero, and writes to them change nothing.
- R12: In variant 0 the diagnostic window holds four bytes selected by `dg_addr_i`, with read data on `dg_rdata_o` one clock after the request. Reset clears the window. In other variants the window reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Word port request |
| reg_we_i | input | 1 | Word port write (1) or read (0) |
| reg_addr_i | input | 6 | Word port byte address |
| reg_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata_i | input | 32 | Word write data |
| reg_rdata_o | output | 32 | Registered word read data |
| dg_req_i | input | 1 | Diagnostic window request |
| dg_we_i | input | 1 | Diagnostic window write (1) or read (0) |
| dg_addr_i | input | 2 | Diagnostic byte index |
| dg_wdata_i | input | 8 | Diagnostic write byte |
| dg_rdata_o | output | 8 | Registered diagnostic read byte |
| err_valid_i | input | 1 | Error capture strobe |
| err_status_i | input | 32 | Captured fault status word |
| err_addr0_i | input | 32 | Captured fault address word 0 |
| err_addr1_i | input | 32 | Captured fault address word 1 |
| irq_o | output | 1 | Fault interrupt |

## Verification
Every result in this block is due exactly one clock after its cause. Write data is readable by a read request issued on the next cycle, and that read's data lands one further clock later. `irq_o` changes on the edge that accepts a capture or a status write. Reset values are visible as soon as reset releases. The bench drives each request on a falling edge and removes it on the following falling edge. It samples outputs on that same falling edge, half a period after the edge that must have produced them, so no check depends on the order of processes at a rising edge. Two instances, variant 1 and variant 0, get identical stimulus. Sweeps over all sixteen word indices are compared against a model of the requirements kept in the bench.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;

  localparam int unsigned DW     = 32;
  localparam int unsigned NPLAIN = 5;

  localparam logic [DW-1:0] DLY_WR_MASK = 32'h7fff_ffff;
  localparam logic [DW-1:0] DLY_RST     = 32'h0000_0020;
  localparam logic [DW-1:0] FA0_RST     = 32'h07c0_0000;

  typedef enum logic [3:0] {
    IDX_ENABLE = 4'd0,
    IDX_DELAY  = 4'd1,
    IDX_FSTAT  = 4'd2,
    IDX_VIDEO  = 4'd3,
    IDX_FADDR0 = 4'd4,
    IDX_FADDR1 = 4'd5,
    IDX_DIAG   = 4'd6,
    IDX_EVCNT0 = 4'd7,
    IDX_EVCNT1 = 4'd8
  } reg_idx_e;

  function automatic logic [DW-1:0] ident_of(int variant);
    case (variant)
      1:       return 32'h1000_0000;
      2:       return 32'h2000_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] en_wr_mask(int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0bff;
  endfunction

  function automatic logic [DW-1:0] en_keep_mask(int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'h0000_0bfc;
  endfunction

  // plain word registers: slot -> word index, write mask, reset value
  function automatic reg_idx_e plain_idx(int slot);
    case (slot)
      0:       return IDX_DELAY;
      1:       return IDX_VIDEO;
      2:       return IDX_DIAG;
      3:       return IDX_EVCNT0;
      default: return IDX_EVCNT1;
    endcase
  endfunction

  function automatic logic [DW-1:0] plain_mask(int slot);
    return (slot == 0) ? DLY_WR_MASK : '1;
  endfunction

  function automatic logic [DW-1:0] plain_rst(int slot);
    return (slot == 0) ? DLY_RST : '0;
  endfunction

endpackage

// File: rtl/ecc_word_reg.sv
module ecc_word_reg #(
  parameter int unsigned     W     = 32,
  parameter logic [W-1:0]    WMASK = '1,
  parameter logic [W-1:0]    RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST;
    else if (we_i) q_q <= wdata_i & WMASK;
  end

  assign q_o = q_q;

  AST_WORD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == ($past(wdata_i) & WMASK)); // R4

  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R10

endmodule

// File: rtl/ecc_enable_reg.sv
module ecc_enable_reg
  import ecc_regbank_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] value_o
);

  localparam logic [DW-1:0] IDENT = ident_of(VARIANT);
  localparam logic [DW-1:0] WMASK = en_wr_mask(VARIANT);
  localparam logic [DW-1:0] KEEP  = en_keep_mask(VARIANT);
  localparam logic [DW-1:0] CLR   = WMASK & ~KEEP;

  logic [DW-1:0] keep_q;
  logic [DW-1:0] clr_q;

  // retained across reset: deliberately no reset term
  always_ff @(posedge clk_i) begin
    if (we_i) keep_q <= wdata_i & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   clr_q <= '0;
    else if (we_i) clr_q <= wdata_i & CLR;
  end

  assign value_o = IDENT | (keep_q & KEEP) | clr_q;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (value_o & WMASK) == ($past(wdata_i) & WMASK)); // R3

  AST_EN_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (value_o & ~WMASK) == IDENT); // R3

endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_stat_i,
  input  logic [DW-1:0] cap_a0_i,
  input  logic [DW-1:0] cap_a1_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] fa0_o,
  output logic [DW-1:0] fa1_o,
  output logic          irq_o
);

  logic [DW-1:0] stat_q, fa0_q, fa1_q;
  logic          irq_q;

  // capture outranks a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      fa0_q  <= FA0_RST;
      fa1_q  <= '0;
      irq_q  <= 1'b0;
    end else if (cap_i) begin
      stat_q <= cap_stat_i;
      fa0_q  <= cap_a0_i;
      fa1_q  <= cap_a1_i;
      irq_q  <= 1'b1;
    end else if (stat_we_i) begin
      stat_q <= wdata_i;
      irq_q  <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign fa0_o  = fa0_q;
  assign fa1_o  = fa1_q;
  assign irq_o  = irq_q;

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> irq_o && stat_o == $past(cap_stat_i)); // R6

  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && !cap_i |=> !irq_o && stat_o == $past(wdata_i)); // R5

  AST_FADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(fa0_o) && $stable(fa1_o)); // R7

endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
  parameter bit          ENABLE = 1'b1,
  parameter int unsigned NBYTES = 4,
  localparam int unsigned AW    = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  if (ENABLE) begin : g_window
    logic [7:0] mem_q [NBYTES];
    logic [7:0] rdata_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NBYTES; i++) mem_q[i] <= '0;
        rdata_q <= '0;
      end else if (req_i) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
        else      rdata_q       <= mem_q[addr_i];
      end
    end

    assign rdata_o = rdata_q;

    AST_DG_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && !we_i) |=> $stable(rdata_o)); // R12
  end else begin : g_absent
    logic unused_dg;
    assign unused_dg = ^{clk_i, rst_ni, req_i, we_i, addr_i, wdata_i};
    assign rdata_o   = '0;
  end

endmodule

// File: rtl/ecc_regbank.sv
module ecc_regbank
  import ecc_regbank_pkg::*;
#(
  parameter int          VARIANT = 1,
  parameter int unsigned ADDR_W  = 6,
  localparam int unsigned IDX_W  = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              dg_req_i,
  input  logic              dg_we_i,
  input  logic [1:0]        dg_addr_i,
  input  logic [7:0]        dg_wdata_i,
  output logic [7:0]        dg_rdata_o,
  input  logic              err_valid_i,
  input  logic [DW-1:0]     err_status_i,
  input  logic [DW-1:0]     err_addr0_i,
  input  logic [DW-1:0]     err_addr1_i,
  output logic              irq_o
);

  localparam logic [DW-1:0] IDENT = ident_of(VARIANT);

  logic             full_acc, wr_en, rd_en;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    en_val, stat_val, fa0_val, fa1_val, rd_word, rdata_q;
  logic [DW-1:0]    plain_q [NPLAIN];

  assign full_acc = (reg_be_i == 4'hf) && (reg_addr_i[1:0] == 2'b00);
  assign idx      = reg_addr_i[ADDR_W-1:2];
  assign wr_en    = reg_req_i &&  reg_we_i && full_acc;
  assign rd_en    = reg_req_i && !reg_we_i;

  ecc_enable_reg #(.VARIANT(VARIANT)) i_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en && idx == IDX_W'(IDX_ENABLE)),
    .wdata_i (reg_wdata_i),
    .value_o (en_val)
  );

  for (genvar s = 0; s < NPLAIN; s++) begin : g_plain
    ecc_word_reg #(
      .W     (DW),
      .WMASK (plain_mask(s)),
      .RST   (plain_rst(s))
    ) i_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en && idx == IDX_W'(plain_idx(s))),
      .wdata_i (reg_wdata_i),
      .q_o     (plain_q[s])
    );
  end

  ecc_fault_capture i_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_we_i  (wr_en && idx == IDX_W'(IDX_FSTAT)),
    .wdata_i    (reg_wdata_i),
    .cap_i      (err_valid_i),
    .cap_stat_i (err_status_i),
    .cap_a0_i   (err_addr0_i),
    .cap_a1_i   (err_addr1_i),
    .stat_o     (stat_val),
    .fa0_o      (fa0_val),
    .fa1_o      (fa1_val),
    .irq_o      (irq_o)
  );

  ecc_diag_window #(.ENABLE(VARIANT == 0), .NBYTES(4)) i_diag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (dg_req_i),
    .we_i    (dg_we_i),
    .addr_i  (dg_addr_i),
    .wdata_i (dg_wdata_i),
    .rdata_o (dg_rdata_o)
  );

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_W'(IDX_ENABLE): rd_word = en_val;
      IDX_W'(IDX_DELAY):  rd_word = plain_q[0];
      IDX_W'(IDX_FSTAT):  rd_word = stat_val;
      IDX_W'(IDX_VIDEO):  rd_word = plain_q[1];
      IDX_W'(IDX_FADDR0): rd_word = fa0_val;
      IDX_W'(IDX_FADDR1): rd_word = fa1_val;
      IDX_W'(IDX_DIAG):   rd_word = plain_q[2];
      IDX_W'(IDX_EVCNT0): rd_word = plain_q[3];
      IDX_W'(IDX_EVCNT1): rd_word = plain_q[4];
      default:            rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= full_acc ? rd_word : '0;
  end

  assign reg_rdata_o = rdata_q;

  AST_IDENT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en && full_acc && idx == IDX_W'(IDX_ENABLE)
    |=> reg_rdata_o[31:24] == IDENT[31:24]); // R3

  AST_UNDECODED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en && idx > IDX_W'(IDX_EVCNT1) |=> reg_rdata_o == '0); // R11

  AST_PARTIAL_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en && !full_acc |=> reg_rdata_o == '0); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(reg_rdata_o)); // R1

endmodule

// File: tb/test_ecc_regbank.sv
module test_ecc_regbank;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req = 0, reg_we = 0;
  logic [5:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        dg_req = 0, dg_we = 0;
  logic [1:0]  dg_addr = '0;
  logic [7:0]  dg_wdata = '0;
  logic [7:0]  dg_a, dg_b;
  logic        err_valid = 0;
  logic [31:0] err_status = '0, err_addr0 = '0, err_addr1 = '0;
  logic        irq_a, irq_b;

  int errors = 0;
  int checks = 0;
  logic [31:0] m [2][16];
  int          var_of [2] = '{1, 0};

  always #10 clk = ~clk;

  // slot 0: variant 1, slot 1: variant 0
  ecc_regbank #(.VARIANT(1)) i_ecc_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_be_i(reg_be), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata_a), .dg_req_i(dg_req), .dg_we_i(dg_we),
    .dg_addr_i(dg_addr), .dg_wdata_i(dg_wdata), .dg_rdata_o(dg_a),
    .err_valid_i(err_valid), .err_status_i(err_status),
    .err_addr0_i(err_addr0), .err_addr1_i(err_addr1), .irq_o(irq_a));

  ecc_regbank #(.VARIANT(0)) i_ecc_regbank_v0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_be_i(reg_be), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata_b), .dg_req_i(dg_req), .dg_we_i(dg_we),
    .dg_addr_i(dg_addr), .dg_wdata_i(dg_wdata), .dg_rdata_o(dg_b),
    .err_valid_i(err_valid), .err_status_i(err_status),
    .err_addr0_i(err_addr0), .err_addr1_i(err_addr1), .irq_o(irq_b));

  function automatic logic [31:0] ident(int v);
    return (v == 1) ? 32'h1000_0000 : ((v == 2) ? 32'h2000_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] after_wr(int v, int idx, logic [31:0] old, logic [31:0] d);
    case (idx)
      0:             return (v == 0) ? (d & 32'h103) : (ident(v) | (d & 32'hbff));
      1:             return d & 32'h7fff_ffff;
      2, 3, 6, 7, 8: return d;
      default:       return old;
    endcase
  endfunction

  function automatic logic [31:0] after_rst(int v, int idx, logic [31:0] old);
    case (idx)
      0:       return (v == 0) ? (old & 32'h100) : (ident(v) | (old & 32'hbfc));
      1:       return 32'h20;
      4:       return 32'h07c0_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      4, 5:    return "R7";
      8:       return "R10";
      9, 10, 11, 12, 13, 14, 15: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 6'(addr); reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic wr_model(int idx, logic [31:0] d);
    wr(idx * 4, d, 4'hf);
    for (int s = 0; s < 2; s++) m[s][idx] = after_wr(var_of[s], idx, m[s][idx], d);
  endtask

  task automatic rd(int addr, logic [3:0] be, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = 6'(addr); reg_be = be;
    @(negedge clk);
    reg_req = 0;
    a = rdata_a; b = rdata_b;
  endtask

  task automatic rd_chk(int idx, string tag);
    logic [31:0] a, b;
    rd(idx * 4, 4'hf, a, b);
    chk(tag, $sformatf("v1 idx%0d", idx), a, m[0][idx]);
    chk(tag, $sformatf("v0 idx%0d", idx), b, m[1][idx]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++) m[s][i] = after_rst(var_of[s], i, m[s][i]);
  endtask

  task automatic capture(logic [31:0] st, logic [31:0] a0, logic [31:0] a1,
                         bit with_wr, logic [31:0] wd);
    @(negedge clk);
    err_valid = 1; err_status = st; err_addr0 = a0; err_addr1 = a1;
    if (with_wr) begin
      reg_req = 1; reg_we = 1; reg_addr = 6'd8; reg_be = 4'hf; reg_wdata = wd;
    end
    @(negedge clk);
    err_valid = 0; reg_req = 0; reg_we = 0;
    for (int s = 0; s < 2; s++) begin
      m[s][2] = st; m[s][4] = a0; m[s][5] = a1;
    end
    chk("R6", "irq v1 after capture", 32'(irq_a), 32'd1);
    chk("R6", "irq v0 after capture", 32'(irq_b), 32'd1);
  endtask

  task automatic dg_wr(int a, logic [7:0] d);
    @(negedge clk);
    dg_req = 1; dg_we = 1; dg_addr = 2'(a); dg_wdata = d;
    @(negedge clk);
    dg_req = 0; dg_we = 0;
  endtask

  task automatic dg_rd(int a, output logic [7:0] ra, output logic [7:0] rb);
    @(negedge clk);
    dg_req = 1; dg_we = 0; dg_addr = 2'(a);
    @(negedge clk);
    dg_req = 0;
    ra = dg_a; rb = dg_b;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b;
    logic [7:0]  ba, bb;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++) m[s][i] = after_rst(var_of[s], i, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R8: reset state (enable retained bits not yet defined)
    chk("R8", "irq v1 reset", 32'(irq_a), 32'd0);
    chk("R8", "irq v0 reset", 32'(irq_b), 32'd0);
    for (int i = 1; i < 9; i++) rd_chk(i, "R8");
    rd(0, 4'hf, a, b);
    chk("R3", "v1 enable identity/clr bits", a & ~32'h0000_0bfc, 32'h1000_0000);
    chk("R3", "v0 enable identity/clr bits", b & ~32'h0000_0100, 32'h0);

    // R3: enable masks
    wr_model(0, 32'hffff_ffff);
    rd_chk(0, "R3");
    wr_model(0, 32'h0fff_f555);
    rd_chk(0, "R3");

    // R1/R3/R4/R5/R7/R10/R11: full sweep with distinct patterns
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 16; i++)
        wr_model(i, (32'h9e37_79b9 * 32'(k + 1)) ^ (32'(i) << (k * 4)) ^ {k[0] ? 32'hffff_ffff : 32'h0});
      for (int i = 0; i < 16; i++) rd_chk(i, tag_of(i));
    end

    // R10: event count 1 independent of event count 0
    wr_model(7, 32'h1111_2222);
    wr_model(8, 32'hdead_beef);
    rd_chk(7, "R10");
    rd_chk(8, "R10");

    // R2: partial or misaligned accesses
    wr_model(3, 32'h3333_3333);
    wr(12, 32'h4444_4444, 4'h3);
    rd_chk(3, "R2");
    wr(14, 32'h5555_5555, 4'hf);
    rd_chk(3, "R2");
    rd(12, 4'h7, a, b);
    chk("R2", "v1 partial read", a, 32'h0);
    chk("R2", "v0 partial read", b, 32'h0);
    rd(13, 4'hf, a, b);
    chk("R2", "v1 misaligned read", a, 32'h0);
    chk("R2", "v0 misaligned read", b, 32'h0);

    // R6/R5: capture then acknowledge
    capture(32'h0001_ff08, 32'hc0de_0001, 32'h8765_4321, 1'b0, 32'h0);
    rd_chk(2, "R6");
    rd_chk(4, "R6");
    rd_chk(5, "R6");
    wr_model(2, 32'h0000_1234);
    chk("R5", "irq v1 after status write", 32'(irq_a), 32'd0);
    chk("R5", "irq v0 after status write", 32'(irq_b), 32'd0);
    rd_chk(2, "R5");
    // R7: bus writes to fault addresses ignored
    wr_model(4, 32'hffff_0000);
    wr_model(5, 32'h0000_ffff);
    rd_chk(4, "R7");
    rd_chk(5, "R7");
    // R6: capture outranks same-cycle status write
    capture(32'h0000_0008, 32'h1357_9bdf, 32'h2468_ace0, 1'b1, 32'h0bad_0bad);
    rd_chk(2, "R6");
    wr_model(2, 32'h0);
    chk("R5", "irq v1 cleared", 32'(irq_a), 32'd0);

    // R9/R8: reset retention of enable bits
    wr_model(0, 32'hffff_ffff);
    for (int i = 1; i < 9; i++) if (i != 4 && i != 5) wr_model(i, 32'ha5a5_5a5a);
    capture(32'h77, 32'h66, 32'h55, 1'b0, 32'h0);
    do_reset();
    chk("R8", "irq v1 after reset", 32'(irq_a), 32'd0);
    chk("R8", "irq v0 after reset", 32'(irq_b), 32'd0);
    rd_chk(0, "R9");
    for (int i = 1; i < 9; i++) rd_chk(i, "R8");
    wr_model(0, 32'h0000_0000);
    do_reset();
    rd_chk(0, "R9");
    wr_model(0, 32'h0000_0a04);
    do_reset();
    rd_chk(0, "R9");

    // R12: diagnostic window
    for (int i = 0; i < 4; i++) dg_wr(i, 8'(8'h3c + 8'(i * 37)));
    dg_wr(2, 8'h99);
    for (int i = 0; i < 4; i++) begin
      dg_rd(i, ba, bb);
      chk("R12", $sformatf("v1 diag byte %0d", i), 32'(ba), 32'h0);
      chk("R12", $sformatf("v0 diag byte %0d", i), 32'(bb),
          (i == 2) ? 32'h99 : 32'(8'(8'h3c + 8'(i * 37))));
    end
    do_reset();
    dg_rd(1, ba, bb);
    chk("R12", "v0 diag after reset", 32'(bb), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule